// File: doc/BRIEF.md
# Audio clock ratio mode selector

This block runs on the master clock of an audio converter. It reports the sampling-speed mode (normal, double or quad) and the number of master clocks in each frame-clock period. The mode can be set by hand from one of two configuration sets. The first is a register-style set with a clock-family bit, two clock-select bits and two speed bits. The second is a pin-style set with two clock-select pins and one speed pin.

A few select codes switch the block to automatic detection instead. In that mode the frame clock is synchronized into the master-clock domain and the master clocks between its rising edges are counted. The count is then classified into one of six nominal ratios, which fold into the three speed modes.

Configuration inputs are captured only while power-down is held high. Changes made while the block is running have no effect. A select combination with no defined ratio raises an invalid-configuration flag, and the previous mode is kept.

Top module: `clk_mode_sel`

## Requirements
- R1: While reset is low, the outputs are: speed 2'b00 (normal), ratio 256, locked 0 and cfg_bad 0.
- R2: Speed is encoded as 00 normal, 01 double and 10 quad, and 11 never appears. With the register set selected (set_sel=0) and clk_family=0, these codes are valid, given as {clk_sel, speed_sel} → (speed, ratio):
  - {00,00} → (normal, 256)
  - {01,00} → (normal, 512), {01,01} → (double, 256), {01,10} → (quad, 128)
  - {10,00} → (normal, 1024), {10,01} → (double, 512), {10,10} → (quad, 256)
- R3: With the register set and clk_family=1, these codes are valid: {00,00} → (normal, 384), {01,00} → (normal, 768), {01,01} → (double, 384) and {01,10} → (quad, 192).
- R4: With the pin set selected (set_sel=1), pin_speed=0 gives normal speed with ratios pin_clk_sel 00→256, 01→512, 10→384 and 11→1024. pin_speed=1 gives double speed with pin_clk_sel 01→256 and 11→512.
- R5: These combinations raise cfg_bad and force locked low, while speed and ratio keep their previous values:
  - register set: speed_sel 11
  - register set, family 0: clk_sel 00 with a nonzero speed_sel, or clk_sel 11 with speed_sel other than 01
  - register set, family 1: clk_sel 00 with a nonzero speed_sel, or clk_sel 10 or 11
  - pin set: pin_clk_sel 00 with pin_speed 1
- R6: Configuration inputs are captured on every rising edge while pwr_dn is 1, and a capture shows on the outputs one edge later. Inputs that change while pwr_dn is 0 leave the outputs unchanged.
- R7: Automatic detection is selected by one of two codes: register set with family 0, clk_sel 11 and speed_sel 01, or pin set with pin_clk_sel 10 and pin_speed 1. In automatic mode cfg_bad is 0. Any valid manual code drives locked to 1.
- R8: In automatic mode, a measured period within ±2 master clocks of 512 or 768 gives normal speed, of 256 or 384 gives double speed, and of 128 or 192 gives quad speed. The ratio output is the matched nominal value.
- R9: The automatic mode changes, and locked goes high, only after two consecutive measured periods match the same nominal value. Before that the previous mode is held and locked is 0.
- R10: A measured period that matches no nominal window clears locked and holds speed and ratio.
- R11: If no frame-clock rising edge arrives for 2048 master clocks, locked is cleared and speed and ratio are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_dn | input | 1 | Power-down; configuration is captured while high |
| set_sel | input | 1 | 0 selects the register set, 1 selects the pin set |
| clk_family | input | 1 | Register set: 0 for the 256 family, 1 for the 384 family |
| clk_sel | input | 2 | Register set clock select |
| speed_sel | input | 2 | Register set speed code |
| pin_clk_sel | input | 2 | Pin set clock select |
| pin_speed | input | 1 | Pin set speed (0 normal, 1 double) |
| fclk | input | 1 | Frame clock, asynchronous to mclk |
| speed | output | 2 | Speed mode: 00 normal, 01 double, 10 quad |
| ratio | output | 11 | Master clocks per frame-clock period |
| locked | output | 1 | The mode is established |
| cfg_bad | output | 1 | The captured configuration has no defined ratio |

## Verification
A manual configuration change is due on the second rising edge after it is driven. The bench drives it on a falling edge and samples on the third falling edge after that.

In automatic mode a frame-clock edge takes three rising edges to reach the detector and one more to reach the outputs. Locking needs three frame edges: one to arm the counter and two for matching periods. The bench therefore samples after six periods for lock and for a mode change. To confirm that no mode change happens early, it samples after one and a half periods.

Out-of-window periods are sampled after four periods, and the timeout case after 2300 idle clocks.

// File: rtl/clk_mode_pkg.sv
package clk_mode_pkg;

   typedef enum logic [1:0] {
      SPD_NORMAL = 2'b00,
      SPD_DOUBLE = 2'b01,
      SPD_QUAD   = 2'b10
   } speed_e;

   // Captured configuration word; the pin set reuses csel and spd[0].
   typedef struct packed {
      logic       par;
      logic       fam;
      logic [1:0] csel;
      logic [1:0] spd;
   } cfg_t;

endpackage

// File: rtl/clk_mode_cfg_dec.sv
module clk_mode_cfg_dec
   import clk_mode_pkg::*;
#(
   parameter int BASE_RATIO = 128,
   parameter int RATIO_W    = 11
) (
   input  cfg_t               cfg,
   output logic               valid,
   output logic               is_auto,
   output speed_e             spd,
   output logic [RATIO_W-1:0] ratio
);
   localparam logic [RATIO_W-1:0] R1X = RATIO_W'(BASE_RATIO);
   localparam logic [RATIO_W-1:0] R15 = RATIO_W'(BASE_RATIO * 3 / 2);
   localparam logic [RATIO_W-1:0] R2X = RATIO_W'(BASE_RATIO * 2);
   localparam logic [RATIO_W-1:0] R3X = RATIO_W'(BASE_RATIO * 3);
   localparam logic [RATIO_W-1:0] R4X = RATIO_W'(BASE_RATIO * 4);
   localparam logic [RATIO_W-1:0] R6X = RATIO_W'(BASE_RATIO * 6);
   localparam logic [RATIO_W-1:0] R8X = RATIO_W'(BASE_RATIO * 8);

   always_comb begin
      valid   = 1'b0;
      is_auto = 1'b0;
      spd     = SPD_NORMAL;
      ratio   = R2X;
      if (cfg.par) begin
         case ({cfg.spd[0], cfg.csel})
            3'b000: begin valid = 1'b1; ratio = R2X; end
            3'b001: begin valid = 1'b1; ratio = R4X; end
            3'b010: begin valid = 1'b1; ratio = R3X; end
            3'b011: begin valid = 1'b1; ratio = R8X; end
            3'b101: begin valid = 1'b1; spd = SPD_DOUBLE; ratio = R2X; end
            3'b110: is_auto = 1'b1;
            3'b111: begin valid = 1'b1; spd = SPD_DOUBLE; ratio = R4X; end
            default: valid = 1'b0;
         endcase
      end else if (!cfg.fam) begin
         case ({cfg.csel, cfg.spd})
            4'b0000: begin valid = 1'b1; ratio = R2X; end
            4'b0100: begin valid = 1'b1; ratio = R4X; end
            4'b0101: begin valid = 1'b1; spd = SPD_DOUBLE; ratio = R2X; end
            4'b0110: begin valid = 1'b1; spd = SPD_QUAD;   ratio = R1X; end
            4'b1000: begin valid = 1'b1; ratio = R8X; end
            4'b1001: begin valid = 1'b1; spd = SPD_DOUBLE; ratio = R4X; end
            4'b1010: begin valid = 1'b1; spd = SPD_QUAD;   ratio = R2X; end
            4'b1101: is_auto = 1'b1;
            default: valid = 1'b0;
         endcase
      end else begin
         case ({cfg.csel, cfg.spd})
            4'b0000: begin valid = 1'b1; ratio = R3X; end
            4'b0100: begin valid = 1'b1; ratio = R6X; end
            4'b0101: begin valid = 1'b1; spd = SPD_DOUBLE; ratio = R3X; end
            4'b0110: begin valid = 1'b1; spd = SPD_QUAD;   ratio = R15; end
            default: valid = 1'b0;
         endcase
      end
   end
endmodule

// File: rtl/clk_mode_ratio_det.sv
module clk_mode_ratio_det
   import clk_mode_pkg::*;
#(
   parameter int BASE_RATIO  = 128,
   parameter int TOL         = 2,
   parameter int TIMEOUT     = 2048,
   parameter int SYNC_STAGES = 2,
   parameter int RATIO_W     = 11
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               fclk,
   output speed_e             det_speed,
   output logic [RATIO_W-1:0] det_ratio,
   output logic               det_locked
);
   localparam int CNT_W = $clog2(TIMEOUT + 1);
   localparam int NCLS  = 6;
   localparam int IDX_W = $clog2(NCLS);

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (TIMEOUT <= 6 * BASE_RATIO + TOL) begin : g_bad_timeout
      $error("TIMEOUT must exceed the longest nominal period");
   end

   function automatic int nom_of(input int i);
      return (((i % 2) == 0) ? BASE_RATIO : (BASE_RATIO * 3 / 2)) << (i / 2);
   endfunction

   function automatic speed_e speed_of(input int i);
      case (i / 2)
         0:       return SPD_QUAD;
         1:       return SPD_DOUBLE;
         default: return SPD_NORMAL;
      endcase
   endfunction

   // Synchronizer plus one stage for edge detection.
   logic [SYNC_STAGES:0] sync_q;
   logic                 rise;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '0;
      else        sync_q <= {sync_q[SYNC_STAGES-1:0], fclk};
   end
   assign rise = sync_q[SYNC_STAGES-1] & ~sync_q[SYNC_STAGES];

   logic [CNT_W-1:0] cnt;
   logic [NCLS-1:0]  hit;
   logic             any_hit;
   logic [IDX_W-1:0] hit_idx;

   for (genvar i = 0; i < NCLS; i++) begin : g_cls
      localparam int NOM = nom_of(i);
      if (TOL == 0) begin : g_exact
         assign hit[i] = (int'(cnt) == NOM);
      end else begin : g_win
         assign hit[i] = (int'(cnt) >= NOM - TOL) && (int'(cnt) <= NOM + TOL);
      end
   end

   always_comb begin
      any_hit = 1'b0;
      hit_idx = '0;
      for (int i = 0; i < NCLS; i++) begin
         if (hit[i] && !any_hit) begin
            any_hit = 1'b1;
            hit_idx = IDX_W'(i);
         end
      end
   end

   logic             armed;
   logic             prev_ok;
   logic [IDX_W-1:0] prev_idx;
   logic             tmo;
   assign tmo = (cnt == CNT_W'(TIMEOUT));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt        <= '0;
         armed      <= 1'b0;
         prev_ok    <= 1'b0;
         prev_idx   <= '0;
         det_speed  <= SPD_NORMAL;
         det_ratio  <= RATIO_W'(BASE_RATIO * 4);
         det_locked <= 1'b0;
      end else if (rise) begin
         cnt   <= CNT_W'(1);
         armed <= 1'b1;
         if (armed) begin
            if (any_hit) begin
               prev_ok  <= 1'b1;
               prev_idx <= hit_idx;
               if (prev_ok && prev_idx == hit_idx) begin
                  det_speed  <= speed_of(int'(hit_idx));
                  det_ratio  <= RATIO_W'(nom_of(int'(hit_idx)));
                  det_locked <= 1'b1;
               end else begin
                  det_locked <= 1'b0;
               end
            end else begin
               prev_ok    <= 1'b0;
               det_locked <= 1'b0;
            end
         end
      end else if (tmo) begin
         armed      <= 1'b0;
         prev_ok    <= 1'b0;
         det_locked <= 1'b0;
      end else begin
         cnt <= cnt + CNT_W'(1);
      end
   end
endmodule

// File: rtl/clk_mode_sel.sv
module clk_mode_sel
   import clk_mode_pkg::*;
#(
   parameter int BASE_RATIO  = 128,
   parameter int TOL         = 2,
   parameter int TIMEOUT     = 2048,
   parameter int SYNC_STAGES = 2,
   parameter int RATIO_W     = 11
) (
   input  logic               mclk,
   input  logic               rst_n,
   input  logic               pwr_dn,
   input  logic               set_sel,
   input  logic               clk_family,
   input  logic [1:0]         clk_sel,
   input  logic [1:0]         speed_sel,
   input  logic [1:0]         pin_clk_sel,
   input  logic               pin_speed,
   input  logic               fclk,
   output logic [1:0]         speed,
   output logic [RATIO_W-1:0] ratio,
   output logic               locked,
   output logic               cfg_bad
);
   if (BASE_RATIO * 8 >= (1 << RATIO_W)) begin : g_bad_width
      $error("RATIO_W too narrow for the largest ratio");
   end
   if (TOL * 4 >= BASE_RATIO) begin : g_bad_tol
      $error("TOL overlaps neighbouring ratio windows");
   end

   cfg_t cfg_d, cfg_q;
   always_comb begin
      if (set_sel) cfg_d = '{par: 1'b1, fam: 1'b0, csel: pin_clk_sel, spd: {1'b0, pin_speed}};
      else         cfg_d = '{par: 1'b0, fam: clk_family, csel: clk_sel, spd: speed_sel};
   end

   always_ff @(posedge mclk or negedge rst_n) begin
      if (!rst_n)      cfg_q <= '0;
      else if (pwr_dn) cfg_q <= cfg_d;
   end

   logic               man_valid, man_auto;
   speed_e             man_speed, det_speed;
   logic [RATIO_W-1:0] man_ratio, det_ratio;
   logic               det_locked;

   clk_mode_cfg_dec #(.BASE_RATIO(BASE_RATIO), .RATIO_W(RATIO_W)) u_dec (
      .cfg(cfg_q), .valid(man_valid), .is_auto(man_auto),
      .spd(man_speed), .ratio(man_ratio)
   );

   clk_mode_ratio_det #(
      .BASE_RATIO(BASE_RATIO), .TOL(TOL), .TIMEOUT(TIMEOUT),
      .SYNC_STAGES(SYNC_STAGES), .RATIO_W(RATIO_W)
   ) u_det (
      .clk(mclk), .rst_n(rst_n), .fclk(fclk),
      .det_speed(det_speed), .det_ratio(det_ratio), .det_locked(det_locked)
   );

   always_ff @(posedge mclk or negedge rst_n) begin
      if (!rst_n) begin
         speed   <= SPD_NORMAL;
         ratio   <= RATIO_W'(BASE_RATIO * 2);
         locked  <= 1'b0;
         cfg_bad <= 1'b0;
      end else if (man_auto) begin
         speed   <= det_speed;
         ratio   <= det_ratio;
         locked  <= det_locked;
         cfg_bad <= 1'b0;
      end else if (man_valid) begin
         speed   <= man_speed;
         ratio   <= man_ratio;
         locked  <= 1'b1;
         cfg_bad <= 1'b0;
      end else begin
         locked  <= 1'b0;
         cfg_bad <= 1'b1;
      end
   end
endmodule

// File: rtl/clk_mode_sel_chk.sv
module clk_mode_sel_chk #(
   parameter int BASE_RATIO = 128,
   parameter int RATIO_W    = 11
) (
   input logic               mclk,
   input logic               rst_n,
   input logic               pwr_dn,
   input logic [5:0]         cfg_word,
   input logic [1:0]         speed,
   input logic [RATIO_W-1:0] ratio,
   input logic               locked,
   input logic               cfg_bad
);
   assert_speed_code_R2: assert property (@(posedge mclk) disable iff (!rst_n)
      speed != 2'b11);

   assert_bad_holds_mode_R5: assert property (@(posedge mclk) disable iff (!rst_n)
      cfg_bad |-> ($stable(speed) && $stable(ratio)));

   assert_bad_unlocked_R5: assert property (@(posedge mclk) disable iff (!rst_n)
      cfg_bad |-> !locked);

   assert_cfg_frozen_R6: assert property (@(posedge mclk) disable iff (!rst_n)
      !pwr_dn |=> $stable(cfg_word));

   assert_quad_band_R8: assert property (@(posedge mclk) disable iff (!rst_n)
      (speed == 2'b10) |-> (int'(ratio) >= BASE_RATIO && int'(ratio) <= 2 * BASE_RATIO));

   assert_double_band_R8: assert property (@(posedge mclk) disable iff (!rst_n)
      (speed == 2'b01) |-> (int'(ratio) >= 2 * BASE_RATIO && int'(ratio) <= 4 * BASE_RATIO));
endmodule

bind clk_mode_sel clk_mode_sel_chk #(.BASE_RATIO(BASE_RATIO), .RATIO_W(RATIO_W)) u_chk (
   .mclk(mclk), .rst_n(rst_n), .pwr_dn(pwr_dn), .cfg_word(cfg_q),
   .speed(speed), .ratio(ratio), .locked(locked), .cfg_bad(cfg_bad)
);

// File: tb/sim_clk_mode_sel.sv
module sim_clk_mode_sel;
   logic        mclk = 1'b0;
   logic        rst_n = 1'b0;
   logic        pwr_dn = 1'b1;
   logic        set_sel = 1'b0, clk_family = 1'b0, pin_speed = 1'b0;
   logic [1:0]  clk_sel = 2'b00, speed_sel = 2'b00, pin_clk_sel = 2'b00;
   logic        fclk;
   logic [1:0]  speed;
   logic [10:0] ratio;
   logic        locked, cfg_bad;

   int n_chk = 0, n_fail = 0;
   int e_spd = 0, e_rat = 256;
   int frame_len = 0;
   bit jitter_en = 1'b0;
   bit done = 1'b0;

   always #2.5 mclk = ~mclk;

   clk_mode_sel u0 (
      .mclk(mclk), .rst_n(rst_n), .pwr_dn(pwr_dn), .set_sel(set_sel),
      .clk_family(clk_family), .clk_sel(clk_sel), .speed_sel(speed_sel),
      .pin_clk_sel(pin_clk_sel), .pin_speed(pin_speed), .fclk(fclk),
      .speed(speed), .ratio(ratio), .locked(locked), .cfg_bad(cfg_bad)
   );

   // Frame-clock generator
   initial begin
      int len;
      fclk = 1'b0;
      forever begin
         if (frame_len == 0) begin
            fclk = 1'b0;
            @(negedge mclk);
         end else begin
            len = frame_len;
            if (jitter_en) len = len + int'($urandom_range(4)) - 2;
            fclk = 1'b1;
            repeat (len / 2) @(negedge mclk);
            fclk = 1'b0;
            repeat (len - len / 2) @(negedge mclk);
         end
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual %0d expected %0d", req, act, exp);
      end
   endtask

   // Expected decode: ok / auto / speed / ratio
   function automatic void exp_cfg(input bit par, input bit fam, input bit [1:0] cs,
                                   input bit [1:0] sp, output bit ok, output bit au,
                                   output int s, output int r);
      ok = 1'b1; au = 1'b0; s = 0; r = 0;
      if (par) begin
         case ({sp[0], cs})
            3'b000: r = 256;
            3'b001: r = 512;
            3'b010: r = 384;
            3'b011: r = 1024;
            3'b101: begin s = 1; r = 256; end
            3'b110: au = 1'b1;
            3'b111: begin s = 1; r = 512; end
            default: ok = 1'b0;
         endcase
      end else if (!fam) begin
         case ({cs, sp})
            4'b0000: r = 256;
            4'b0100: r = 512;
            4'b0101: begin s = 1; r = 256; end
            4'b0110: begin s = 2; r = 128; end
            4'b1000: r = 1024;
            4'b1001: begin s = 1; r = 512; end
            4'b1010: begin s = 2; r = 256; end
            4'b1101: au = 1'b1;
            default: ok = 1'b0;
         endcase
      end else begin
         case ({cs, sp})
            4'b0000: r = 384;
            4'b0100: r = 768;
            4'b0101: begin s = 1; r = 384; end
            4'b0110: begin s = 2; r = 192; end
            default: ok = 1'b0;
         endcase
      end
      if (au) ok = 1'b0;
   endfunction

   task automatic drive_cfg(input bit par, input bit fam, input bit [1:0] cs, input bit [1:0] sp);
      @(negedge mclk);
      pwr_dn = 1'b1;
      set_sel = par;
      if (par) begin
         pin_clk_sel = cs; pin_speed = sp[0];
         clk_family = 1'($urandom); clk_sel = 2'($urandom); speed_sel = 2'($urandom);
      end else begin
         clk_family = fam; clk_sel = cs; speed_sel = sp;
         pin_clk_sel = 2'($urandom); pin_speed = 1'($urandom);
      end
      repeat (3) @(negedge mclk);
   endtask

   task automatic manual_case(input bit par, input bit fam, input bit [1:0] cs, input bit [1:0] sp);
      bit ok, au;
      int s, r;
      string tag;
      exp_cfg(par, fam, cs, sp, ok, au, s, r);
      if (au) return;
      drive_cfg(par, fam, cs, sp);
      if (!ok) tag = "R5";
      else if (par) tag = "R4";
      else if (fam) tag = "R3";
      else tag = "R2";
      if (ok) begin e_spd = s; e_rat = r; end
      chk({tag, " speed"}, int'(speed), e_spd);
      chk({tag, " ratio"}, int'(ratio), e_rat);
      chk({tag, " cfg_bad"}, int'(cfg_bad), ok ? 0 : 1);
      chk({tag, " locked R7"}, int'(locked), ok ? 1 : 0);
   endtask

   task automatic auto_run(input int len, input int es, input int er, input string tag);
      frame_len = len;
      repeat (6 * (len + 2) + 20) @(negedge mclk);
      chk({tag, " auto speed"}, int'(speed), es);
      chk({tag, " auto ratio"}, int'(ratio), er);
      chk({tag, " auto locked R9"}, int'(locked), 1);
      chk({tag, " auto cfg_bad R7"}, int'(cfg_bad), 0);
   endtask

   initial begin
      void'($urandom(32'd20250611));
      repeat (3) @(negedge mclk);
      // R1: reset state
      chk("R1 speed", int'(speed), 0);
      chk("R1 ratio", int'(ratio), 256);
      chk("R1 locked", int'(locked), 0);
      chk("R1 cfg_bad", int'(cfg_bad), 0);
      rst_n = 1'b1;

      // Exhaustive manual tables R2 R3 R4 R5
      for (int f = 0; f < 2; f++)
         for (int c = 0; c < 4; c++)
            for (int s = 0; s < 4; s++)
               manual_case(1'b0, 1'(f), 2'(c), 2'(s));
      for (int c = 0; c < 4; c++)
         for (int s = 0; s < 2; s++)
            manual_case(1'b1, 1'b0, 2'(c), 2'(s));

      // Random mix
      for (int i = 0; i < 60; i++)
         manual_case(1'($urandom), 1'($urandom), 2'($urandom), 2'($urandom));

      // R6: changes while running are ignored
      manual_case(1'b0, 1'b1, 2'b01, 2'b00);
      for (int i = 0; i < 12; i++) begin
         @(negedge mclk);
         pwr_dn = 1'b0;
         set_sel = 1'($urandom); clk_family = 1'($urandom); clk_sel = 2'($urandom);
         speed_sel = 2'($urandom); pin_clk_sel = 2'($urandom); pin_speed = 1'($urandom);
         repeat (3) @(negedge mclk);
         chk("R6 speed held", int'(speed), 0);
         chk("R6 ratio held", int'(ratio), 768);
         chk("R6 cfg_bad held", int'(cfg_bad), 0);
      end

      // R7: enter automatic mode via register code
      drive_cfg(1'b0, 1'b0, 2'b11, 2'b01);
      @(negedge mclk); pwr_dn = 1'b0;
      chk("R7 auto no cfg_bad", int'(cfg_bad), 0);
      chk("R9 unlocked at entry", int'(locked), 0);
      frame_len = 256;
      repeat (256 + 100) @(negedge mclk);
      chk("R9 one period no lock", int'(locked), 0);
      chk("R9 one period mode held", int'(ratio), 512);
      auto_run(256, 1, 256, "R8");
      auto_run(512, 0, 512, "R8");
      auto_run(768, 0, 768, "R8");
      jitter_en = 1'b1;
      auto_run(384, 1, 384, "R8 jitter");
      auto_run(128, 2, 128, "R8 jitter");
      auto_run(192, 2, 192, "R8 jitter");
      jitter_en = 1'b0;

      // R10: unmatched period
      frame_len = 300;
      repeat (4 * 300) @(negedge mclk);
      chk("R10 locked", int'(locked), 0);
      chk("R10 speed held", int'(speed), 2);
      chk("R10 ratio held", int'(ratio), 192);

      // R11: frame clock stops
      auto_run(512, 0, 512, "R11 pre");
      frame_len = 0;
      repeat (2300) @(negedge mclk);
      chk("R11 locked", int'(locked), 0);
      chk("R11 speed held", int'(speed), 0);
      chk("R11 ratio held", int'(ratio), 512);

      // R7: enter automatic mode via pin code
      drive_cfg(1'b1, 1'b0, 2'b10, 2'b01);
      @(negedge mclk); pwr_dn = 1'b0;
      auto_run(384, 1, 384, "R7 pin");

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge mclk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual %0d expected %0d", 0, 1);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule